// File: doc/BRIEF.md
# Eight-Way Cache Tag and Replacement Controller

This block holds the tag and line-state array of one eight-way set-associative cache with 32-byte lines. Each cycle it accepts one operation: a lookup (read or write), a fill, or a snoop invalidate. A lookup reports, one cycle later, whether the line is present and in which way. On a miss it also names the way a later fill will replace and whether that line is dirty and needs a write-back first.

Each set keeps seven tree bits for pseudo-LRU replacement. Free ways are always used before any valid line is evicted. In data mode each line carries a Modified/Exclusive/Invalid state. A parameter turns the block into an instruction-side tag array, where a line only has a valid bit.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line is invalid, every tree bit is 0 and all result outputs are 0. The first lookup of any address misses, names victim way 0 and asks for no write-back.
- R2: An address splits into a 5-bit byte offset (bits 4:0), a set index of log2(SETS) bits above it, and a tag in the remaining upper bits. A lookup hits when a valid line of the indexed set holds the tag, whatever the offset. `res_valid`, `res_hit` and `res_way` appear in the cycle after the request.
- R3: While a set has an invalid way, the victim is the lowest-numbered invalid way.
- R4: When all eight ways are valid, the victim is found by walking the tree. Bit 0 chooses ways 0-3 (value 0) or ways 4-7 (value 1). Bits 1 and 2 choose the pair inside the lower and upper half. Bits 3 to 6 choose inside the pairs (0,1), (2,3), (4,5), (6,7). At every node 0 means the lower-numbered side.
- R5: A lookup hit or a fill sets the three tree bits on the accessed way's path so that each points to the other side.
- R6: A fill whose address misses writes the tag into the victim way in Exclusive state. A fill whose address already hits only refreshes the tree and leaves the line's state unchanged.
- R7: In data mode a write lookup that hits makes the line Modified. A read hit leaves the state unchanged, and a miss changes nothing.
- R8: A lookup miss asserts `res_wb` exactly when the victim way is Modified. The state encoding is {dirty, valid}: Invalid 00, Exclusive 01, Modified 11.
- R9: A snoop that hits makes the line Invalid and reports `snp_hit`, with `snp_dirty` set if the line was Modified. The snoop leaves the tree bits alone. A snoop miss changes nothing.
- R10: A snoop takes priority over a fill, and a fill over a lookup. A lower-priority request in the same cycle is dropped: no `res_valid` for a dropped lookup and no state change.
- R11: With ICACHE=1 a line has only a valid bit. Write lookups never make a line dirty, and `res_wb` and `snp_dirty` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write |
| lk_addr | input | ADDR_W | Lookup address |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | ADDR_W | Address of the line being installed |
| snp_valid | input | 1 | Snoop invalidate request |
| snp_addr | input | ADDR_W | Snoop address |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 3 | Way that hit |
| res_victim | output | 3 | Way chosen for replacement |
| res_wb | output | 1 | Victim is Modified and needs a write-back |
| snp_done | output | 1 | Snoop result valid |
| snp_hit | output | 1 | Snoop found the line |
| snp_dirty | output | 1 | Snooped line was Modified |

## Verification
The assertions assume that only one fill installs a given line. The block itself never creates a second copy of a tag in a set, because a fill that already hits is treated as a refresh. That is why the one-hot hit check can hold for any input sequence. The stimulus draws tags from a pool larger than the way count, spread over two sets. Sets therefore fill up, overflow into tree replacement and see random snoops and refills. Requests that collide in the same cycle are generated on purpose to exercise the priority order. A data-mode instance and an instruction-mode instance receive identical stimulus.

// File: rtl/cache_tag_pkg.sv
// Shared constants and line-state encoding for the cache tag controller.
// Assumes a fixed eight-way organisation with 32-byte lines.
package cache_tag_pkg;
    localparam int WAYS   = 8;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;
    localparam int OFF_W  = 5;

    // Encoding is {dirty, valid}.
    typedef enum logic [1:0] {
        LS_INV  = 2'b00,
        LS_EXCL = 2'b01,
        LS_MOD  = 2'b11
    } line_state_t;
endpackage

// File: rtl/ctl_tag_match.sv
// Compares one tag against the eight ways of a set and encodes the hit way.
// Assumes no set ever holds the same valid tag twice.
module ctl_tag_match
    import cache_tag_pkg::*;
#(
    parameter int TAG_W = 23
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0]             valid,
    input  logic [TAG_W-1:0]            tag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    // One comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == tag);
    end

    // Encode the matching way.
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end

    // R2
    onehot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/ctl_plru8.sv
// Picks the replacement way for one set and computes the updated tree bits.
// The tree is a heap: node k has children 2k+1 and 2k+2, and leaves 7..14 are ways 0..7.
// Assumes acc_way is the way being touched this cycle.
module ctl_plru8
    import cache_tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TREE_W-1:0] tree,
    input  logic [WAYS-1:0]   valid,
    input  logic [WAY_W-1:0]  acc_way,
    output logic [WAY_W-1:0]  victim,
    output logic [TREE_W-1:0] tree_nxt
);
    function automatic logic [WAY_W-1:0] walk(input logic [TREE_W-1:0] t);
        logic r, m, l;
        r = t[0];
        m = r ? t[2] : t[1];
        l = t[3 + {r, m}];
        return {r, m, l};
    endfunction

    // Take the lowest invalid way first, otherwise walk the tree.
    always_comb begin
        victim = walk(tree);
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) victim = WAY_W'(i);
        end
    end

    // Make every node on the accessed path point to the other side.
    always_comb begin
        tree_nxt = tree;
        tree_nxt[0] = ~acc_way[2];
        tree_nxt[1 + acc_way[2]] = ~acc_way[1];
        tree_nxt[3 + acc_way[2:1]] = ~acc_way[0];
    end

    // R5
    away_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk(tree_nxt) != acc_way);
    // R3
    invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid != '1) |-> !valid[victim]);
endmodule

// File: rtl/cache_tag_ctrl.sv
// Tag and state array of an eight-way cache: hit/miss, pseudo-LRU victim,
// MEI line state, write-back flag and snoop invalidation.
// Assumes the data array acts on res_* and performs the fill later.
// Handles one operation per cycle: snoop, then fill, then lookup.
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 16,
    parameter bit ICACHE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [2:0]        res_way,
    output logic [2:0]        res_victim,
    output logic              res_wb,
    output logic              snp_done,
    output logic              snp_hit,
    output logic              snp_dirty
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam bit DIRTY_EN = !ICACHE;

    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            val_q   [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];
    logic [TREE_W-1:0]          tree_q  [SETS];

    logic              do_snp, do_fill, do_lk;
    logic [ADDR_W-1:0] op_addr;
    logic [IDX_W-1:0]  op_idx;
    logic [TAG_W-1:0]  op_tag;
    logic [WAYS-1:0]   hit_vec, set_dirty;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, victim, acc_way;
    logic [TREE_W-1:0] tree_nxt;
    line_state_t       vic_state, hit_state;
    logic              unused_off;

    // Select the single operation served this cycle.
    always_comb begin
        do_snp  = snp_valid;
        do_fill = fill_valid && !snp_valid;
        do_lk   = lk_valid && !fill_valid && !snp_valid;
        op_addr = do_snp ? snp_addr : (do_fill ? fill_addr : lk_addr);
    end

    assign op_idx     = op_addr[OFF_W +: IDX_W];
    assign op_tag     = op_addr[ADDR_W-1 -: TAG_W];
    assign unused_off = ^op_addr[OFF_W-1:0];
    assign set_dirty  = dirty_q[op_idx] & val_q[op_idx];
    assign acc_way    = hit ? hit_way : victim;
    assign vic_state  = line_state_t'({set_dirty[victim], val_q[op_idx][victim]});
    assign hit_state  = line_state_t'({set_dirty[hit_way], hit});

    ctl_tag_match #(.TAG_W(TAG_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .tags    (tag_q[op_idx]),
        .valid   (val_q[op_idx]),
        .tag     (op_tag),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_way (hit_way)
    );

    ctl_plru8 u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .tree     (tree_q[op_idx]),
        .valid    (val_q[op_idx]),
        .acc_way  (acc_way),
        .victim   (victim),
        .tree_nxt (tree_nxt)
    );

    // Register the results and update tags, states and tree bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]   <= '0;
                val_q[s]   <= '0;
                dirty_q[s] <= '0;
                tree_q[s]  <= '0;
            end
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_way    <= '0;
            res_victim <= '0;
            res_wb     <= 1'b0;
            snp_done   <= 1'b0;
            snp_hit    <= 1'b0;
            snp_dirty  <= 1'b0;
        end else begin
            res_valid  <= do_lk;
            res_hit    <= do_lk && hit;
            res_way    <= hit_way;
            res_victim <= victim;
            res_wb     <= do_lk && !hit && (vic_state == LS_MOD);
            snp_done   <= do_snp;
            snp_hit    <= do_snp && hit;
            snp_dirty  <= do_snp && (hit_state == LS_MOD);
            if (do_lk && hit) begin
                tree_q[op_idx] <= tree_nxt;
                if (lk_write && DIRTY_EN) dirty_q[op_idx][hit_way] <= 1'b1;
            end
            if (do_fill) begin
                tree_q[op_idx] <= tree_nxt;
                if (!hit) begin
                    tag_q[op_idx][victim]   <= op_tag;
                    val_q[op_idx][victim]   <= 1'b1;
                    dirty_q[op_idx][victim] <= 1'b0;
                end
            end
            if (do_snp && hit) begin
                val_q[op_idx][hit_way]   <= 1'b0;
                dirty_q[op_idx][hit_way] <= 1'b0;
            end
        end
    end

    // R8
    wb_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_wb) |-> !res_hit);
    // R9
    snp_dirty_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty |-> (snp_hit && snp_done));
    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && snp_done));
    // R11
    icache_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ICACHE |-> !(res_wb || snp_dirty));
endmodule

// File: tb/sim_cache_tag_ctrl.sv
// Bench: drives a data-mode instance (u0) and an instruction-mode instance (u1)
// with the same stimulus and checks both against bench reference models.
module sim_cache_tag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 16;
    localparam int TAG_W = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, lk_write = 0, fill_valid = 0, snp_valid = 0;
    logic [31:0] lk_addr = '0, fill_addr = '0, snp_addr = '0;

    logic       rv [2], rh [2], rwb [2], sd [2], sh [2], sdy [2];
    logic [2:0] rway [2], rvic [2];

    int n_tests = 0;
    int n_fail  = 0;
    string dtag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_tag_ctrl #(.ADDR_W(32), .SETS(SETS), .ICACHE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write), .lk_addr(lk_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .res_valid(rv[0]), .res_hit(rh[0]), .res_way(rway[0]), .res_victim(rvic[0]),
        .res_wb(rwb[0]), .snp_done(sd[0]), .snp_hit(sh[0]), .snp_dirty(sdy[0]));

    cache_tag_ctrl #(.ADDR_W(32), .SETS(SETS), .ICACHE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write), .lk_addr(lk_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .res_valid(rv[1]), .res_hit(rh[1]), .res_way(rway[1]), .res_victim(rvic[1]),
        .res_wb(rwb[1]), .snp_done(sd[1]), .snp_hit(sh[1]), .snp_dirty(sdy[1]));

    // Reference model state, one copy per mode.
    bit [TAG_W-1:0] mt [2][SETS][8];
    bit             mv [2][SETS][8];
    bit             md [2][SETS][8];
    bit [6:0]       mtree [2][SETS];

    int e_rv[2], e_hit[2], e_way[2], e_vic[2], e_wb[2], e_sd[2], e_sh[2], e_sdy[2], e_allv[2];

    function automatic string tg(input string def);
        return (dtag != "") ? dtag : def;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int t, input int s, input int o);
        return {TAG_W'(t), 4'(s), 5'(o)};
    endfunction

    // Lowest free way, else heap walk (R3, R4).
    function automatic int m_victim(input int m, input int s);
        int n;
        for (int w = 0; w < 8; w++) if (!mv[m][s][w]) return w;
        n = 0;
        while (n < 7) n = 2 * n + 1 + int'(mtree[m][s][n]);
        return n - 7;
    endfunction

    // Climb from the leaf, pointing each parent away from the way (R5).
    task automatic m_touch(input int m, input int s, input int w);
        int n, p;
        n = w + 7;
        while (n > 0) begin
            p = (n - 1) / 2;
            mtree[m][s][p] = (n % 2 == 1);
            n = p;
        end
    endtask

    task automatic model(input int m, input bit lk, input bit wr, input logic [31:0] la,
                         input bit fl, input logic [31:0] fa, input bit sn, input logic [31:0] sa);
        logic [31:0] a;
        int s, hw, v;
        bit [TAG_W-1:0] t;
        bit h;
        e_rv[m] = 0; e_sd[m] = 0;
        a = sn ? sa : (fl ? fa : la);
        s = int'(a[8:5]);
        t = a[31:9];
        h = 0; hw = 0;
        for (int w = 0; w < 8; w++) if (mv[m][s][w] && mt[m][s][w] == t) begin h = 1; hw = w; end
        v = m_victim(m, s);
        e_allv[m] = 1;
        for (int w = 0; w < 8; w++) if (!mv[m][s][w]) e_allv[m] = 0;
        if (sn) begin
            e_sd[m] = 1; e_sh[m] = h; e_sdy[m] = h && md[m][s][hw];
            if (h) begin mv[m][s][hw] = 0; md[m][s][hw] = 0; end
        end else if (fl) begin
            if (h) m_touch(m, s, hw);
            else begin
                mt[m][s][v] = t; mv[m][s][v] = 1; md[m][s][v] = 0; m_touch(m, s, v);
            end
        end else if (lk) begin
            e_rv[m] = 1; e_hit[m] = h; e_way[m] = hw; e_vic[m] = v;
            e_wb[m] = !h && mv[m][s][v] && md[m][s][v];
            if (h) begin
                m_touch(m, s, hw);
                if (wr && m == 0) md[m][s][hw] = 1;
            end
        end
    endtask

    task automatic step(input bit lk, input bit wr, input logic [31:0] la,
                        input bit fl, input logic [31:0] fa, input bit sn, input logic [31:0] sa);
        @(negedge clk);
        lk_valid = lk; lk_write = wr; lk_addr = la;
        fill_valid = fl; fill_addr = fa; snp_valid = sn; snp_addr = sa;
        for (int m = 0; m < 2; m++) model(m, lk, wr, la, fl, fa, sn, sa);
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; snp_valid = 0;
        for (int m = 0; m < 2; m++) begin
            chk(tg("R10"), $sformatf("u%0d res_valid", m), int'(rv[m]), e_rv[m]);
            if (e_rv[m] != 0) begin
                chk(tg("R2"), $sformatf("u%0d res_hit", m), int'(rh[m]), e_hit[m]);
                if (e_hit[m] != 0)
                    chk(tg("R2"), $sformatf("u%0d res_way", m), int'(rway[m]), e_way[m]);
                else begin
                    chk(tg(e_allv[m] != 0 ? "R4" : "R3"), $sformatf("u%0d res_victim", m),
                        int'(rvic[m]), e_vic[m]);
                    chk(tg(m == 1 ? "R11" : "R8"), $sformatf("u%0d res_wb", m), int'(rwb[m]), e_wb[m]);
                end
            end
            chk(tg("R10"), $sformatf("u%0d snp_done", m), int'(sd[m]), e_sd[m]);
            if (e_sd[m] != 0) begin
                chk(tg("R9"), $sformatf("u%0d snp_hit", m), int'(sh[m]), e_sh[m]);
                chk(tg(m == 1 ? "R11" : "R9"), $sformatf("u%0d snp_dirty", m), int'(sdy[m]), e_sdy[m]);
            end
        end
    endtask

    task automatic lookup(input bit wr, input logic [31:0] a); step(1, wr, a, 0, '0, 0, '0); endtask
    task automatic fill(input logic [31:0] a);                 step(0, 0, '0, 1, a, 0, '0); endtask
    task automatic snoop(input logic [31:0] a);                step(0, 0, '0, 0, '0, 1, a); endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int r;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle after reset, first lookup misses into way 0.
        for (int m = 0; m < 2; m++) begin
            chk("R1", "res_valid", int'(rv[m]), 0);
            chk("R1", "res_wb", int'(rwb[m]), 0);
            chk("R1", "snp_done", int'(sd[m]), 0);
        end
        dtag = "R1"; lookup(0, mk(1, 0, 3));
        // R6: fill all eight ways, then each tag hits in its way.
        dtag = "R6";
        for (int i = 0; i < 8; i++) fill(mk(i + 1, 0, 0));
        for (int i = 0; i < 8; i++) lookup(0, mk(i + 1, 0, i * 3));
        fill(mk(4, 0, 0));
        // R4: all ways valid, tree decides.
        dtag = "R4"; lookup(0, mk(30, 0, 0));
        // R2: same line with other offsets.
        dtag = "R2"; lookup(0, mk(2, 0, 31)); lookup(0, mk(2, 1, 0));
        // R5: after touching way 5 the victim must move elsewhere.
        dtag = "R5"; lookup(0, mk(6, 0, 0)); lookup(0, mk(31, 0, 0));
        // R7: write hit makes the line dirty, seen through the snoop.
        dtag = "R7"; fill(mk(40, 3, 0)); lookup(1, mk(40, 3, 0)); snoop(mk(40, 3, 0));
        // R8: dirty line in way 0 becomes the victim.
        dtag = "R8";
        for (int i = 0; i < 8; i++) fill(mk(50 + i, 1, 0));
        lookup(1, mk(50, 1, 0));
        for (int i = 1; i < 8; i++) lookup(0, mk(50 + i, 1, 0));
        lookup(0, mk(70, 1, 0));
        // R9: snoop miss, snoop hit, then the line misses.
        dtag = "R9"; snoop(mk(99, 1, 0)); snoop(mk(53, 1, 0)); lookup(0, mk(53, 1, 0));
        // R3: the freed way is taken first.
        dtag = "R3"; lookup(0, mk(98, 1, 0));
        // R10: collisions drop the lower-priority request.
        dtag = "R10";
        step(1, 0, mk(51, 1, 0), 0, '0, 1, mk(52, 1, 0));
        step(1, 0, mk(51, 1, 0), 1, mk(60, 1, 0), 0, '0);
        lookup(0, mk(60, 1, 0));
        dtag = "";
        // Random mix over two sets and a twelve-tag pool.
        for (int i = 0; i < 3000; i++) begin
            r = int'($urandom_range(0, 99));
            if (r < 40)      lookup(1'($urandom), mk(int'($urandom_range(1, 12)), int'($urandom_range(0, 1)), int'($urandom_range(0, 31))));
            else if (r < 75) fill(mk(int'($urandom_range(1, 12)), int'($urandom_range(0, 1)), 0));
            else if (r < 90) snoop(mk(int'($urandom_range(1, 12)), int'($urandom_range(0, 1)), 0));
            else step(1'($urandom), 1'($urandom), mk(int'($urandom_range(1, 12)), int'($urandom_range(0, 1)), 0),
                      1'($urandom), mk(int'($urandom_range(1, 12)), int'($urandom_range(0, 1)), 0),
                      1'($urandom), mk(int'($urandom_range(1, 12)), int'($urandom_range(0, 1)), 0));
        end
        finish_run();
    end
endmodule